// File: doc/BRIEF.md
# Stacked-Band Carrier PWM Modulator for a Nine-Level Matrix Inverter

This block is the modulation core for a single-phase nine-level inverter. In that inverter the DC sources and the power switches are arranged as a small matrix. The block makes eight triangular carriers that all follow one shared triangle. Each carrier sits in its own vertical band of the signed reference range, so the eight stack without gaps. The block compares a sampled sinusoidal reference against all eight carriers on every clock. The number of carriers the reference lies above, minus four, is the instantaneous output level, from -4 to +4.

That level is then decoded into the gate pattern for the matrix switches. For every nonzero level exactly three switches of the level set conduct. Negative levels reuse the magnitude decode and swap the polarity leg pair. The zero level closes a fixed return pair that carries no source. The amplitude of the output voltage follows the amplitude of the reference. The carrier step input sets how far the shared triangle moves per clock, which sets the carrier frequency.

Top module: `stacked_carrier_pwm`

## Requirements
- R1: While `rst_n` is low, `level_o` is 0 and `gate_o` is the zero pattern 9'b000010001 (bits 0 and 4 set). The shared triangle value is 0 and is rising.
- R2: On each clock edge, `level_o` becomes N-4. N is the number of carriers k in 0..7 for which `ref_i` is strictly greater than C_k = -2^(REF_W-1) + k·2^(REF_W-3) + T, where T is the triangle value before that edge.
- R3: The triangle T is unsigned and runs from 0 to PEAK = 2^(REF_W-3)-2. On each edge it moves by `step_i`: upward while rising, clamping at PEAK and then falling; downward while falling, clamping at 0 and then rising. With `step_i` = 0 it holds, so after reset the carriers stay at their band bottoms. At the default width, `ref_i` = -1024 then gives level -2 and `ref_i` = -1023 gives level -1.
- R4: `ref_i` equal to the most positive code gives level +4 after the next edge, whatever the triangle value. The most negative code gives level -4.
- R5: On the edge after `level_o` holds a positive value L, `gate_o[6:0]` takes the set for L and `gate_o[8:7]` becomes 2'b01. The set for L=1 is bits {1,3,4}, for L=2 bits {2,3,4}, for L=3 bits {2,3,5}, and for L=4 bits {2,3,6}.
- R6: For a negative level -L, `gate_o[6:0]` takes the same set as for +L and `gate_o[8:7]` becomes 2'b10.
- R7: For level 0, `gate_o` becomes 9'b000010001. A reference of 0 always gives level 0.
- R8: `gate_o` changes only on a clock edge and always reflects the `level_o` value held during the previous cycle (one register of lag).
- R9: Whenever a polarity leg bit is set, exactly three of `gate_o[6:0]` are set, and at most one of `gate_o[8:7]` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | REF_W | Signed reference sample |
| step_i | input | STEP_W | Unsigned triangle increment per clock |
| gate_o | output | 9 | Registered gate vector: [6:0] level set, [8:7] polarity legs |
| level_o | output | 4 | Signed output level code, -4 to +4 |

## Verification
The reference is first held at fixed values while the step is zero, so the carriers sit at their band bottoms. This separates a strict compare from a non-strict one at the exact band edges. A full-scale sine with a moderate step then walks through all nine levels in both directions, with the triangle at every phase, and exposes wrong band offsets or decode rows. A sine below half scale must never leave the ±2 range, which catches a misplaced band. The reference is also held at the extreme codes and at zero with a large step, so the triangle bounces hard between its clamps; this shows whether the saturating reversal keeps the carriers inside their bands.

// File: rtl/stacked_carrier_pkg.sv
package stacked_carrier_pkg;
   localparam int GATE_W = 9;
   localparam int LVL_W  = 4;
   typedef logic [GATE_W-1:0]        gate_t;
   typedef logic signed [LVL_W-1:0]  lvl_t;
   // return pair only, no polarity leg
   localparam gate_t GATE_ZERO = 9'b00_0010001;
   localparam logic [1:0] LEG_POS = 2'b01;
   localparam logic [1:0] LEG_NEG = 2'b10;
endpackage

// File: rtl/shared_triangle.sv
module shared_triangle #(
   parameter int TRI_W  = 9,
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STEP_W-1:0] step_i,
   output logic [TRI_W-1:0]  tri_o
);
   localparam logic [TRI_W:0] PEAK = (TRI_W+1)'((2**TRI_W) - 2);

   logic             rising_q;
   logic [TRI_W-1:0] tri_q;
   logic [TRI_W:0]   step_ext;
   logic [TRI_W:0]   up_sum;
   logic [TRI_W:0]   dn_diff;

   assign step_ext = (TRI_W+1)'(step_i);
   assign up_sum   = {1'b0, tri_q} + step_ext;
   assign dn_diff  = {1'b0, tri_q} - step_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tri_q    <= '0;
         rising_q <= 1'b1;
      end else if (rising_q) begin
         if (up_sum >= PEAK) begin
            tri_q    <= PEAK[TRI_W-1:0];
            rising_q <= 1'b0;
         end else begin
            tri_q <= up_sum[TRI_W-1:0];
         end
      end else begin
         if ({1'b0, tri_q} <= step_ext) begin
            tri_q    <= '0;
            rising_q <= 1'b1;
         end else begin
            tri_q <= dn_diff[TRI_W-1:0];
         end
      end
   end

   assign tri_o = tri_q;
endmodule

// File: rtl/band_compare.sv
module band_compare
   import stacked_carrier_pkg::*;
#(
   parameter int REF_W = 12,
   parameter int NCAR  = 8,
   parameter int TRI_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [REF_W-1:0] ref_i,
   input  logic [TRI_W-1:0]        tri_i,
   output lvl_t                    lvl_o
);
   localparam int BAND_H = 2**TRI_W;
   localparam int LOW    = -(2**(REF_W-1));
   localparam int CNT_W  = $clog2(NCAR+1);
   localparam int XW     = REF_W + 2;

   logic signed [XW-1:0] ref_ext;
   logic signed [XW-1:0] tri_ext;
   logic [NCAR-1:0]      above;
   logic [CNT_W-1:0]     cnt;
   logic signed [LVL_W:0] diff;
   lvl_t                 lvl_q;

   assign ref_ext = {{2{ref_i[REF_W-1]}}, ref_i};
   assign tri_ext = {{(XW-TRI_W){1'b0}}, tri_i};

   for (genvar k = 0; k < NCAR; k++) begin : g_band
      localparam int BASE = LOW + k * BAND_H;
      localparam logic signed [XW-1:0] BASE_V = XW'(BASE);
      logic signed [XW-1:0] carrier;
      assign carrier  = BASE_V + tri_ext;
      assign above[k] = (ref_ext > carrier);
   end

   always_comb begin
      cnt = '0;
      for (int k = 0; k < NCAR; k++) begin
         cnt = cnt + CNT_W'(above[k]);
      end
   end

   assign diff = $signed((LVL_W+1)'(cnt)) - $signed((LVL_W+1)'(NCAR/2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= diff[LVL_W-1:0];
   end

   assign lvl_o = lvl_q;
endmodule

// File: rtl/matrix_gate_map.sv
module matrix_gate_map
   import stacked_carrier_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  lvl_t  lvl_i,
   output gate_t gate_o
);
   logic signed [LVL_W:0] lv_ext;
   logic signed [LVL_W:0] mag;
   logic [6:0]            set_bits;
   logic [1:0]            legs;
   gate_t                 gate_d;
   gate_t                 gate_q;

   assign lv_ext = {lvl_i[LVL_W-1], lvl_i};
   assign mag    = lv_ext[LVL_W] ? -lv_ext : lv_ext;

   always_comb begin
      unique case (mag[2:0])
         3'd1:    set_bits = 7'b0011010;
         3'd2:    set_bits = 7'b0011100;
         3'd3:    set_bits = 7'b0101100;
         3'd4:    set_bits = 7'b1001100;
         default: set_bits = GATE_ZERO[6:0];
      endcase
      if (lv_ext[LVL_W])      legs = LEG_NEG;
      else if (lv_ext != '0)  legs = LEG_POS;
      else                    legs = 2'b00;
      gate_d = {legs, set_bits};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= GATE_ZERO;
      else        gate_q <= gate_d;
   end

   assign gate_o = gate_q;
endmodule

// File: rtl/stacked_carrier_pwm.sv
module stacked_carrier_pwm
   import stacked_carrier_pkg::*;
#(
   parameter int REF_W    = 12,
   parameter int STEP_W   = 8,
   parameter int N_LEVELS = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [REF_W-1:0] ref_i,
   input  logic [STEP_W-1:0]       step_i,
   output logic [8:0]              gate_o,
   output logic signed [3:0]       level_o
);
   localparam int NCAR    = N_LEVELS - 1;
   localparam int BAND_SH = $clog2(NCAR);
   localparam int TRI_W   = REF_W - BAND_SH;

   if (N_LEVELS != 9) begin : g_bad_levels
      $error("switch decode is defined for nine levels only");
   end
   if (REF_W < 6) begin : g_bad_ref
      $error("REF_W too small for eight bands");
   end
   if (STEP_W > TRI_W - 1) begin : g_bad_step
      $error("STEP_W must be below the band width");
   end

   logic [TRI_W-1:0] tri_val;
   lvl_t             lvl;
   gate_t            gates;

   shared_triangle #(.TRI_W(TRI_W), .STEP_W(STEP_W)) i_tri (
      .clk   (clk),
      .rst_n (rst_n),
      .step_i(step_i),
      .tri_o (tri_val)
   );

   band_compare #(.REF_W(REF_W), .NCAR(NCAR), .TRI_W(TRI_W)) i_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .ref_i (ref_i),
      .tri_i (tri_val),
      .lvl_o (lvl)
   );

   matrix_gate_map i_map (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (lvl),
      .gate_o(gates)
   );

   assign level_o = lvl;
   assign gate_o  = gates;
endmodule

// File: rtl/stacked_carrier_pwm_chk.sv
module stacked_carrier_pwm_chk #(
   parameter int REF_W = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic signed [REF_W-1:0] ref_i,
   input logic [8:0]              gate_o,
   input logic signed [3:0]       level_o
);
   localparam logic signed [REF_W-1:0] REF_MAX = {1'b0, {(REF_W-1){1'b1}}};
   localparam logic signed [REF_W-1:0] REF_MIN = {1'b1, {(REF_W-1){1'b0}}};

   a_r2_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o >= -4) && (level_o <= 4));

   a_r4_top_code: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_i == REF_MAX) |=> (level_o == 4));

   a_r4_bottom_code: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_i == REF_MIN) |=> (level_o == -4));

   a_r7_zero_ref: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_i == '0) |=> (level_o == 0));

   a_r7_zero_map: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(level_o) == 0) |-> (gate_o == 9'b000010001));

   a_r5_pos_leg: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(level_o) > 0) |-> (gate_o[8:7] == 2'b01));

   a_r6_neg_leg: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(level_o) < 0) |-> (gate_o[8:7] == 2'b10));

   a_r9_three_on: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_o[8:7] != 2'b00) |-> ($countones(gate_o[6:0]) == 3));

   a_r9_legs_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gate_o[8:7]));
endmodule

bind stacked_carrier_pwm stacked_carrier_pwm_chk #(.REF_W(REF_W)) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ref_i  (ref_i),
   .gate_o (gate_o),
   .level_o(level_o)
);

// File: tb/test_stacked_carrier_pwm.sv
module test_stacked_carrier_pwm;
   localparam int REF_W  = 12;
   localparam int STEP_W = 8;
   localparam int BAND_H = 2**(REF_W-3);
   localparam int PEAK   = BAND_H - 2;
   localparam int LOW    = -(2**(REF_W-1));
   localparam int RMAX   = 2**(REF_W-1) - 1;
   localparam logic [8:0] ZERO_PAT = 9'b000010001;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic signed [REF_W-1:0] ref_i = '0;
   logic [STEP_W-1:0]       step_i = '0;
   logic [8:0]              gate_o;
   logic signed [3:0]       level_o;

   int nchk = 0;
   int nfail = 0;
   int mtri;
   bit mup;
   int exp_lvl;
   logic [8:0] exp_gate;
   int max_seen;

   always #4 clk = ~clk;

   stacked_carrier_pwm #(.REF_W(REF_W), .STEP_W(STEP_W), .N_LEVELS(9)) i_stacked_carrier_pwm (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .step_i(step_i),
      .gate_o(gate_o), .level_o(level_o)
   );

   function automatic int model_level(int r, int t);
      int n = 0;
      for (int k = 0; k < 8; k++) if (r > LOW + k * BAND_H + t) n++;
      return n - 4;
   endfunction

   function automatic logic [8:0] model_gate(int l);
      int m = (l < 0) ? -l : l;
      logic [6:0] s;
      logic [1:0] g;
      case (m)
         1: s = 7'b0011010;
         2: s = 7'b0011100;
         3: s = 7'b0101100;
         4: s = 7'b1001100;
         default: s = 7'b0010001;
      endcase
      g = (l > 0) ? 2'b01 : ((l < 0) ? 2'b10 : 2'b00);
      return {g, s};
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: drive at negedge, advance model, compare at next negedge
   task automatic cycle(int r, int s);
      int nl;
      logic [8:0] ng;
      int lv;
      string gtag;
      ref_i  = REF_W'(r);
      step_i = STEP_W'(s);
      nl = model_level(r, mtri);
      ng = model_gate(exp_lvl);
      if (mup) begin
         if (mtri + s >= PEAK) begin mtri = PEAK; mup = 1'b0; end
         else mtri = mtri + s;
      end else begin
         if (mtri <= s) begin mtri = 0; mup = 1'b1; end
         else mtri = mtri - s;
      end
      @(posedge clk);
      @(negedge clk);
      gtag = (exp_lvl > 0) ? "R8 gate lag, R5 table" :
             ((exp_lvl < 0) ? "R8 gate lag, R6 table" : "R8 gate lag, R7 table");
      exp_lvl  = nl;
      exp_gate = ng;
      lv = level_o;
      check(lv == exp_lvl, "R2 level", lv, exp_lvl);
      check(gate_o == exp_gate, gtag, int'(gate_o), int'(exp_gate));
      if (exp_gate[8:7] != 2'b00)
         check($countones(gate_o[6:0]) == 3, "R9 three on", $countones(gate_o[6:0]), 3);
      if (lv > max_seen) max_seen = lv;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin : main
      int lv;
      repeat (3) @(posedge clk);
      @(negedge clk);
      lv = level_o;
      check(lv == 0, "R1 reset level", lv, 0);
      check(gate_o == ZERO_PAT, "R1 reset gate", int'(gate_o), int'(ZERO_PAT));
      rst_n = 1'b1;
      mtri = 0; mup = 1'b1; exp_lvl = 0; exp_gate = ZERO_PAT;

      // carriers frozen at band bottoms: strict compare at the edges
      cycle(-1024, 0);
      lv = level_o;
      check(lv == -2, "R3 frozen band edge", lv, -2);
      cycle(-1023, 0);
      lv = level_o;
      check(lv == -1, "R3 frozen above edge", lv, -1);
      cycle(1, 0);
      cycle(0, 0);
      cycle(1024, 0);
      cycle(1025, 0);
      cycle(LOW, 0);

      // extremes with a fast bouncing triangle
      for (int i = 0; i < 40; i++) cycle(RMAX, 200);
      lv = level_o;
      check(lv == 4, "R4 top code", lv, 4);
      for (int i = 0; i < 40; i++) cycle(LOW, 255);
      lv = level_o;
      check(lv == -4, "R4 bottom code", lv, -4);
      for (int i = 0; i < 40; i++) cycle(0, 131);
      lv = level_o;
      check(lv == 0, "R7 zero reference", lv, 0);
      check(gate_o == ZERO_PAT, "R7 zero pattern", int'(gate_o), int'(ZERO_PAT));

      // full-scale sine
      for (int n = 0; n < 2400; n++)
         cycle(int'($rtoi(2040.0 * $sin(6.283185307 * n / 400.0))), 37);

      // reduced amplitude sine stays within two levels
      max_seen = -5;
      for (int n = 0; n < 1600; n++)
         cycle(int'($rtoi(900.0 * $sin(6.283185307 * n / 320.0))), 23);
      check(max_seen <= 2, "R2 reduced amplitude", max_seen, 2);

      // step changes mid-run
      for (int n = 0; n < 600; n++)
         cycle(int'($rtoi(1500.0 * $sin(6.283185307 * n / 150.0))), (n / 50) * 21);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule